// File: doc/BRIEF.md
# Two-Channel DMA Bus Arbiter

This block decides, one transfer unit at a time, who drives a shared system bus: the CPU or one of the DMA channels. Each channel presents a request line and a mode line. The mode line selects one of two behaviours. A burst channel keeps the bus for back-to-back units until it lowers its request. A cycle-steal channel hands the bus back to the CPU after every unit.

A global input selects fixed priority, where the lowest-numbered channel wins, or rotating priority, where the channel served last drops to the bottom. Rotation has no meaning when a burst requester and a cycle-steal requester compete. In that case the arbiter raises an error flag and uses fixed priority.

A granted channel sees a one-cycle start pulse at the beginning of each unit. It ends the unit with a one-cycle done pulse. Arbitration only happens while the CPU owns the bus or at the done pulse of the owning channel. A unit in flight is never pre-empted.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While reset (active-low `rstN`) is asserted and in the cycle after release, `grantCpu` is 1, `grantCh` is 0, `unitGo` is 0 and `modeErr` is 0.
- R2: Exactly one of `grantCpu`, `grantCh[0]`, `grantCh[1]` is 1 in every cycle.
- R3: With `roundRobin`=0, when the CPU owns the bus and channel 0 requests, channel 0 owns the bus in the next cycle, whatever channel 1 requests.
- R4: A channel's grant does not change until that channel pulses its own `unitDone` bit. Done pulses from a channel that does not own the bus and new requests are ignored meanwhile.
- R5: When the owning channel has `chBurst`=1 and still requests in its done cycle, it keeps the grant in the next cycle, with no CPU cycle in between.
- R6: When the owning channel has `chBurst`=0 (cycle steal), the CPU owns the bus in the cycle after its done pulse, even if requests are pending.
- R7: When the owning channel's request is 0 in its done cycle, the CPU owns the bus in the next cycle.
- R8: With `roundRobin`=1 and both requesters in the same mode, the channel that completed the last unit loses to the other channel at the next arbitration.
- R9: With `roundRobin`=1, at an arbitration where both channels request and their `chBurst` values differ, `modeErr` becomes 1 in the next cycle and fixed priority decides. `modeErr` is re-evaluated only while the CPU owns the bus, and it returns to 0 after an arbitration without that conflict.
- R10: `unitGo` is 1 for exactly the first cycle of each unit, both for a newly granted channel and for a continuing burst. It is 0 at all other times.
- R11: While no channel requests, the CPU keeps the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| roundRobin | input | 1 | 1 selects rotating priority, 0 fixed priority |
| chReq | input | NUM_CH | Per-channel transfer request |
| chBurst | input | NUM_CH | Per-channel mode: 1 burst, 0 cycle steal |
| unitDone | input | NUM_CH | Per-channel one-cycle pulse ending a unit |
| grantCpu | output | 1 | CPU owns the bus |
| grantCh | output | NUM_CH | Channel owns the bus |
| unitGo | output | 1 | First cycle of a transfer unit for the granted channel |
| modeErr | output | 1 | Rotation requested with mixed-mode requesters |

## Verification
The bench builds the block with its default of two channels. With that setting every ownership pattern can be reached: CPU interleaving between cycle-steal units, unbroken burst runs, rotation in both directions, and the mixed-mode fallback. The expected grant, start pulse and error flag are scripted per cycle from the requirements. They cover done pulses from a channel that does not own the bus, requests that arrive mid-unit, and requests dropped in the done cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic markServed;  // owning channel finished a unit this cycle
    logic sampleMode;  // this cycle is an arbitration point
  } arbStrobe_t;

endpackage

// File: rtl/dma_arb_datapath.sv
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chReq,
  input  logic [NUM_CH-1:0] chBurst,
  input  logic              roundRobin,
  input  arbStrobe_t        strobe,
  input  logic [IDX_W-1:0]  servedIdx,
  output logic              winnerValid,
  output logic [IDX_W-1:0]  winnerIdx,
  output logic              modeErr
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

  logic [IDX_W-1:0] lastServed;
  logic             mixedReq;
  logic             rotateEn;
  logic [IDX_W-1:0] fixedIdx;
  logic [IDX_W-1:0] rotIdx;
  logic             fixedHit;
  logic             rotHit;

  // Burst and cycle-steal requesters competing at once.
  assign mixedReq = (|(chReq & chBurst)) && (|(chReq & ~chBurst));
  assign rotateEn = roundRobin && !mixedReq;

  // Fixed order: lowest index wins.
  always_comb begin
    fixedHit = 1'b0;
    fixedIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (chReq[i]) begin
        fixedHit = 1'b1;
        fixedIdx = IDX_W'(i);
      end
    end
  end

  // Rotating order: search starts just after the channel served last.
  always_comb begin
    rotHit = 1'b0;
    rotIdx = '0;
    for (int off = NUM_CH; off >= 1; off--) begin
      int cand;
      cand = int'(lastServed) + off;
      if (cand >= NUM_CH) cand = cand - NUM_CH;
      if (chReq[cand]) begin
        rotHit = 1'b1;
        rotIdx = IDX_W'(cand);
      end
    end
  end

  assign winnerValid = rotateEn ? rotHit : fixedHit;
  assign winnerIdx   = rotateEn ? rotIdx : fixedIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastServed <= LAST_IDX;
      modeErr    <= 1'b0;
    end else begin
      if (strobe.markServed) lastServed <= servedIdx;
      if (strobe.sampleMode) modeErr <= roundRobin && mixedReq;
    end
  end

  // A winner always names a requesting channel.
  AST_WINNER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    winnerValid |-> chReq[winnerIdx]);  // R3

  // Under rotation without conflict, the last served channel loses to another requester.
  AST_ROTATE_AWAY: assert property (@(posedge clk) disable iff (!rstN)
    (rotateEn && winnerValid && ($countones(chReq) > 1)) |-> (winnerIdx != lastServed));  // R8

endmodule

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chReq,
  input  logic [NUM_CH-1:0] chBurst,
  input  logic [NUM_CH-1:0] unitDone,
  input  logic              winnerValid,
  input  logic [IDX_W-1:0]  winnerIdx,
  output logic [NUM_CH:0]   grantVec,   // bit 0 CPU, bit i+1 channel i
  output logic              unitGo,
  output arbStrobe_t        strobe,
  output logic [IDX_W-1:0]  ownerIdx
);

  localparam logic [NUM_CH:0] CPU_OWNS = (NUM_CH + 1)'(1);

  logic [NUM_CH-1:0] ownerCh;
  logic              ownerDone;
  logic              ownerKeeps;
  logic [NUM_CH:0]   grantNext;
  logic              goNext;

  assign ownerCh    = grantVec[NUM_CH:1];
  assign ownerDone  = |(unitDone & ownerCh);
  assign ownerKeeps = |(ownerCh & chBurst & chReq);

  always_comb begin
    ownerIdx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ownerCh[i]) ownerIdx = IDX_W'(i);
    end
  end

  always_comb begin
    grantNext         = grantVec;
    goNext            = 1'b0;
    strobe.markServed = 1'b0;
    strobe.sampleMode = 1'b0;
    if (grantVec[0]) begin
      strobe.sampleMode = 1'b1;
      if (winnerValid) begin
        grantNext = '0;
        grantNext[int'(winnerIdx) + 1] = 1'b1;
        goNext = 1'b1;
      end
    end else if (ownerDone) begin
      strobe.markServed = 1'b1;
      if (ownerKeeps) begin
        goNext = 1'b1;
      end else begin
        grantNext = CPU_OWNS;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantVec <= CPU_OWNS;
      unitGo   <= 1'b0;
    end else begin
      grantVec <= grantNext;
      unitGo   <= goNext;
    end
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(grantVec));  // R2

  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rstN)
    (!grantVec[0] && !ownerDone) |=> $stable(grantVec));  // R4

  AST_BURST_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (ownerDone && ownerKeeps) |=> ($stable(grantVec) && unitGo));  // R5

  AST_STEAL_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (|(unitDone & ownerCh & ~chBurst)) |=> grantVec[0]);  // R6

  AST_DROP_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (|(unitDone & ownerCh & ~chReq)) |=> grantVec[0]);  // R7

  AST_GO_CHANNEL: assert property (@(posedge clk) disable iff (!rstN)
    unitGo |-> !grantVec[0]);  // R10

  AST_IDLE_CPU: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec[0] && !(|chReq)) |=> grantVec[0]);  // R11

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              roundRobin,
  input  logic [NUM_CH-1:0] chReq,
  input  logic [NUM_CH-1:0] chBurst,
  input  logic [NUM_CH-1:0] unitDone,
  output logic              grantCpu,
  output logic [NUM_CH-1:0] grantCh,
  output logic              unitGo,
  output logic              modeErr
);

  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  arbStrobe_t       strobe;
  logic             winnerValid;
  logic [IDX_W-1:0] winnerIdx;
  logic [IDX_W-1:0] ownerIdx;
  logic [NUM_CH:0]  grantVec;

  dma_arb_ctrl #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .chReq       (chReq),
    .chBurst     (chBurst),
    .unitDone    (unitDone),
    .winnerValid (winnerValid),
    .winnerIdx   (winnerIdx),
    .grantVec    (grantVec),
    .unitGo      (unitGo),
    .strobe      (strobe),
    .ownerIdx    (ownerIdx)
  );

  dma_arb_datapath #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .chReq       (chReq),
    .chBurst     (chBurst),
    .roundRobin  (roundRobin),
    .strobe      (strobe),
    .servedIdx   (ownerIdx),
    .winnerValid (winnerValid),
    .winnerIdx   (winnerIdx),
    .modeErr     (modeErr)
  );

  assign grantCpu = grantVec[0];
  assign grantCh  = grantVec[NUM_CH:1];

  AST_FIXED_CH0: assert property (@(posedge clk) disable iff (!rstN)
    (grantCpu && chReq[0] && !roundRobin) |=> grantCh[0]);  // R3

endmodule

// File: tb/dma_bus_arbiter_bench.sv
module dma_bus_arbiter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 2;
  localparam int WATCHDOG   = 5000;

  localparam logic [2:0] G_CPU = 3'b001;
  localparam logic [2:0] G_CH0 = 3'b010;
  localparam logic [2:0] G_CH1 = 3'b100;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              roundRobin = 1'b0;
  logic [NUM_CH-1:0] chReq = '0;
  logic [NUM_CH-1:0] chBurst = '0;
  logic [NUM_CH-1:0] unitDone = '0;
  logic              grantCpu;
  logic [NUM_CH-1:0] grantCh;
  logic              unitGo;
  logic              modeErr;

  int cyc = 0;
  int errors = 0;
  int checks = 0;

  typedef struct {
    int         due;
    logic [2:0] grant;
    logic       go;
    logic       err;
    string      tag;
  } expItem_t;

  expItem_t sbQueue[$];

  dma_bus_arbiter #(.NUM_CH(NUM_CH)) u_dma_bus_arbiter (
    .clk        (clk),
    .rstN       (rstN),
    .roundRobin (roundRobin),
    .chReq      (chReq),
    .chBurst    (chBurst),
    .unitDone   (unitDone),
    .grantCpu   (grantCpu),
    .grantCh    (grantCh),
    .unitGo     (unitGo),
    .modeErr    (modeErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Advance to just after the next edge, then apply inputs.
  task automatic drive(input logic [1:0] req, input logic [1:0] burst,
                       input logic [1:0] done, input logic rr);
    @(posedge clk);
    #1;
    chReq = req;
    chBurst = burst;
    unitDone = done;
    roundRobin = rr;
  endtask

  // Expect outputs at the negedge 'ahead' cycles from now.
  task automatic expect_out(input int ahead, input logic [2:0] g, input logic go,
                            input logic err, input string tag);
    expItem_t it;
    it.due = cyc + ahead;
    it.grant = g;
    it.go = go;
    it.err = err;
    it.tag = tag;
    sbQueue.push_back(it);
  endtask

  // Monitor: compare outputs away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      while (sbQueue.size() > 0 && sbQueue[0].due <= cyc) begin
        expItem_t it;
        logic [2:0] got;
        it = sbQueue.pop_front();
        got = {grantCh, grantCpu};
        checks++;
        if (it.due != cyc) begin
          errors++;
          $display("FAIL %s: check missed its cycle (due %0d, now %0d)", it.tag, it.due, cyc);
        end else if (got != it.grant || unitGo != it.go || modeErr != it.err) begin
          errors++;
          $display("FAIL %s @%0d: grant=%b go=%b err=%b expected grant=%b go=%b err=%b",
                   it.tag, cyc, got, unitGo, modeErr, it.grant, it.go, it.err);
        end
        checks++;
        if ($countones(got) != 1) begin
          errors++;
          $display("FAIL R2 @%0d: grant=%b expected one-hot", cyc, got);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion within %0d cycles", WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state, during and just after reset
    repeat (3) @(posedge clk);
    #1;
    expect_out(0, G_CPU, 1'b0, 1'b0, "R1");
    @(posedge clk);
    #1;
    rstN = 1'b1;
    expect_out(0, G_CPU, 1'b0, 1'b0, "R1");

    // Fixed priority, both cycle steal
    drive(2'b11, 2'b00, 2'b00, 1'b0); expect_out(1, G_CH0, 1'b1, 1'b0, "R3");
    drive(2'b11, 2'b00, 2'b01, 1'b0); expect_out(1, G_CPU, 1'b0, 1'b0, "R6");
    drive(2'b11, 2'b00, 2'b00, 1'b0); expect_out(1, G_CH0, 1'b1, 1'b0, "R3");
    drive(2'b00, 2'b00, 2'b01, 1'b0); expect_out(1, G_CPU, 1'b0, 1'b0, "R7");
    drive(2'b00, 2'b00, 2'b00, 1'b0); expect_out(1, G_CPU, 1'b0, 1'b0, "R11");
    drive(2'b00, 2'b11, 2'b00, 1'b0); expect_out(1, G_CPU, 1'b0, 1'b0, "R11");

    // Burst on channel 1, interference mid-unit
    drive(2'b10, 2'b11, 2'b00, 1'b0); expect_out(1, G_CH1, 1'b1, 1'b0, "R10");
    drive(2'b11, 2'b11, 2'b00, 1'b0); expect_out(1, G_CH1, 1'b0, 1'b0, "R4");
    drive(2'b11, 2'b11, 2'b01, 1'b0); expect_out(1, G_CH1, 1'b0, 1'b0, "R4");
    drive(2'b11, 2'b11, 2'b10, 1'b0); expect_out(1, G_CH1, 1'b1, 1'b0, "R5");
    drive(2'b01, 2'b11, 2'b10, 1'b0); expect_out(1, G_CPU, 1'b0, 1'b0, "R7");
    drive(2'b01, 2'b11, 2'b00, 1'b0); expect_out(1, G_CH0, 1'b1, 1'b0, "R3");
    drive(2'b01, 2'b11, 2'b01, 1'b0); expect_out(1, G_CH0, 1'b1, 1'b0, "R5");
    drive(2'b00, 2'b11, 2'b01, 1'b0); expect_out(1, G_CPU, 1'b0, 1'b0, "R7");
    drive(2'b00, 2'b00, 2'b00, 1'b0); expect_out(1, G_CPU, 1'b0, 1'b0, "R11");

    // Rotation, both cycle steal; last served is channel 0
    drive(2'b11, 2'b00, 2'b00, 1'b1); expect_out(1, G_CH1, 1'b1, 1'b0, "R8");
    drive(2'b11, 2'b00, 2'b10, 1'b1); expect_out(1, G_CPU, 1'b0, 1'b0, "R6");
    drive(2'b11, 2'b00, 2'b00, 1'b1); expect_out(1, G_CH0, 1'b1, 1'b0, "R8");
    drive(2'b11, 2'b00, 2'b01, 1'b1); expect_out(1, G_CPU, 1'b0, 1'b0, "R6");
    drive(2'b11, 2'b00, 2'b00, 1'b1); expect_out(1, G_CH1, 1'b1, 1'b0, "R8");
    drive(2'b00, 2'b00, 2'b10, 1'b1); expect_out(1, G_CPU, 1'b0, 1'b0, "R7");

    // Make channel 0 the last served, then mix modes under rotation
    drive(2'b01, 2'b00, 2'b00, 1'b1); expect_out(1, G_CH0, 1'b1, 1'b0, "R10");
    drive(2'b01, 2'b00, 2'b01, 1'b1); expect_out(1, G_CPU, 1'b0, 1'b0, "R6");
    drive(2'b11, 2'b01, 2'b00, 1'b1); expect_out(1, G_CH0, 1'b1, 1'b1, "R9");
    drive(2'b11, 2'b01, 2'b01, 1'b1); expect_out(1, G_CH0, 1'b1, 1'b1, "R9");
    drive(2'b10, 2'b01, 2'b01, 1'b1); expect_out(1, G_CPU, 1'b0, 1'b1, "R9");
    drive(2'b10, 2'b01, 2'b00, 1'b1); expect_out(1, G_CH1, 1'b1, 1'b0, "R9");
    drive(2'b00, 2'b01, 2'b10, 1'b1); expect_out(1, G_CPU, 1'b0, 1'b0, "R6");
    drive(2'b00, 2'b00, 2'b00, 1'b0); expect_out(1, G_CPU, 1'b0, 1'b0, "R11");

    repeat (4) @(posedge clk);
    @(negedge clk);
    if (sbQueue.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard: %0d items left, expected 0", sbQueue.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule